// File: doc/BRIEF.md
# Bit-Sliced Integer ALU with Status Flags

This block is a purely combinational integer ALU for a processor datapath. It takes two operands and a 4-bit operation code. It returns a result word and three status flags: zero, signed overflow and carry-out. The supported operations are AND, OR, NOR, add, subtract and signed set-on-less-than.

Each result bit is produced by its own slice. A slice can invert its A bit, invert its B bit, and then pick one of four values: the AND of the two, the OR of the two, the adder sum, or a less-than input. The op code drives these controls directly. Bit 3 inverts A, bit 2 inverts B, and the low two bits pick the value.

The carry chain is chosen by a parameter. It is either a plain ripple chain or a two-level lookahead built from 4-bit groups. A subtract feeds its B-invert control in as the carry into bit 0.

Top module: `alu_core`

## Requirements
- R1: Op code 4'b0000 gives `a & b` and op code 4'b0001 gives `a | b`.
- R2: Op code 4'b0010 gives `a + b` modulo 2^32.
- R3: Op code 4'b0110 gives `a - b` modulo 2^32.
- R4: Op code 4'b0111 gives 32'd1 when `a` is less than `b` as signed two's-complement numbers, and 32'd0 otherwise. This holds even when `a - b` overflows, for example with 0x80000000 against 0x7FFFFFFF.
- R5: Op code 4'b1100 gives `~(a | b)`.
- R6: Every op code outside the six above gives a result of 0.
- R7: `zero` is 1 exactly when all 32 result bits are 0. This holds for every op code, including the unused ones.
- R8: For every op code, `overflow` is the signed overflow of the internal sum S = (a ^ {32{op[3]}}) + (b ^ {32{op[2]}}) + op[2]. It is 1 when both adder operands have the same sign bit and bit 31 of S differs from that sign bit.
- R9: For every op code, `carry_out` is bit 32 of the 33-bit sum S defined in R8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 32 | First operand |
| b | input | 32 | Second operand |
| op | input | 4 | Operation code: [3] inverts A, [2] inverts B and sets the carry into bit 0, [1:0] picks the slice output |
| result | output | 32 | Operation result |
| zero | output | 1 | High when the result is all zeros |
| overflow | output | 1 | Signed overflow of the internal adder |
| carry_out | output | 1 | Carry out of the top bit of the internal adder |

## Verification
The block has no clock, so the checker evaluates its properties combinationally. It assumes the operands and op code are held steady long enough for the outputs to settle, with no change in the middle of an evaluation. The bench changes inputs only on the falling edge of its clock and compares outputs one nanosecond later. The properties also assume the op code has no unknown bits, and the bench always drives all four bits to 0 or 1.

// File: rtl/alu_pkg.sv
package alu_pkg;

  localparam logic [3:0] OP_AND = 4'b0000;
  localparam logic [3:0] OP_OR  = 4'b0001;
  localparam logic [3:0] OP_ADD = 4'b0010;
  localparam logic [3:0] OP_SUB = 4'b0110;
  localparam logic [3:0] OP_SLT = 4'b0111;
  localparam logic [3:0] OP_NOR = 4'b1100;

  typedef enum logic [1:0] {
    PICK_AND  = 2'b00,
    PICK_OR   = 2'b01,
    PICK_SUM  = 2'b10,
    PICK_LESS = 2'b11
  } pick_e;

  typedef struct packed {
    logic  inv_a;
    logic  inv_b;
    pick_e pick;
    logic  legal;
  } slice_ctrl_t;

endpackage

// File: rtl/alu_decode.sv
module alu_decode
  import alu_pkg::*;
(
  input  logic [3:0]  op,
  output slice_ctrl_t ctrl
);

  always_comb begin
    ctrl.inv_a = op[3];
    ctrl.inv_b = op[2];
    ctrl.pick  = pick_e'(op[1:0]);
    unique case (op)
      OP_AND, OP_OR, OP_ADD, OP_SUB, OP_SLT, OP_NOR: ctrl.legal = 1'b1;
      default:                                      ctrl.legal = 1'b0;
    endcase
  end

endmodule

// File: rtl/alu_slice.sv
module alu_slice
  import alu_pkg::*;
(
  input  logic  a,
  input  logic  b,
  input  logic  inv_a,
  input  logic  inv_b,
  input  pick_e pick,
  input  logic  cin,
  input  logic  less,
  output logic  res,
  output logic  sum,
  output logic  gen,
  output logic  prop
);

  logic a_eff;
  logic b_eff;

  always_comb begin
    a_eff = a ^ inv_a;
    b_eff = b ^ inv_b;
    gen   = a_eff & b_eff;
    prop  = a_eff | b_eff;
    sum   = a_eff ^ b_eff ^ cin;
    unique case (pick)
      PICK_AND: res = gen;
      PICK_OR:  res = prop;
      PICK_SUM: res = sum;
      default:  res = less;
    endcase
  end

endmodule

// File: rtl/alu_carry.sv
module alu_carry #(
  parameter int W         = 32,
  parameter int GRP       = 4,
  parameter bit LOOKAHEAD = 1'b1
) (
  input  logic [W-1:0] g,
  input  logic [W-1:0] p,
  input  logic         cin,
  output logic [W:0]   c
);

  localparam int NG = W / GRP;

  generate
    if (LOOKAHEAD) begin : g_cla
      logic [NG-1:0] grp_g;
      logic [NG-1:0] grp_p;
      logic [NG:0]   grp_c;

      // group generate / propagate
      always_comb begin
        for (int k = 0; k < NG; k++) begin
          grp_g[k] = 1'b0;
          grp_p[k] = 1'b1;
          for (int i = 0; i < GRP; i++) begin
            grp_g[k] = g[k*GRP+i] | (p[k*GRP+i] & grp_g[k]);
            grp_p[k] = grp_p[k] & p[k*GRP+i];
          end
        end
      end

      // second-level lookahead across groups, sum-of-products form
      always_comb begin
        logic run;
        grp_c = '0;
        grp_c[0] = cin;
        for (int k = 1; k <= NG; k++) begin
          run = 1'b1;
          for (int j = k - 1; j >= 0; j--) begin
            grp_c[k] = grp_c[k] | (run & grp_g[j]);
            run      = run & grp_p[j];
          end
          grp_c[k] = grp_c[k] | (run & cin);
        end
      end

      // first-level lookahead inside each group
      always_comb begin
        logic run;
        c = '0;
        for (int k = 0; k < NG; k++) begin
          c[k*GRP] = grp_c[k];
          for (int i = 1; i < GRP; i++) begin
            run = 1'b1;
            for (int j = i - 1; j >= 0; j--) begin
              c[k*GRP+i] = c[k*GRP+i] | (run & g[k*GRP+j]);
              run        = run & p[k*GRP+j];
            end
            c[k*GRP+i] = c[k*GRP+i] | (run & grp_c[k]);
          end
        end
        c[W] = grp_c[NG];
      end
    end else begin : g_ripple
      assign c[0] = cin;
      for (genvar i = 0; i < W; i++) begin : g_bit
        assign c[i+1] = g[i] | (p[i] & c[i]);
      end
    end
  endgenerate

endmodule

// File: rtl/alu_flags.sv
module alu_flags #(
  parameter int W = 32
) (
  input  logic [W-1:0] res,
  input  logic         sum_msb,
  input  logic         c_into_msb,
  input  logic         c_out_msb,
  output logic         zero,
  output logic         ovf,
  output logic         set
);

  always_comb begin
    zero = ~(|res);
    ovf  = c_into_msb ^ c_out_msb;
    set  = sum_msb ^ ovf;
  end

endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int W         = 32,
  parameter int GRP       = 4,
  parameter bit LOOKAHEAD = 1'b1
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [3:0]   op,
  output logic [W-1:0] result,
  output logic         zero,
  output logic         overflow,
  output logic         carry_out
);

  slice_ctrl_t  ctrl;
  logic [W-1:0] raw;
  logic [W-1:0] sum;
  logic [W-1:0] gen;
  logic [W-1:0] prop;
  logic [W-1:0] less;
  logic [W:0]   cy;
  logic         set_lt;

  alu_decode u_dec (
    .op   (op),
    .ctrl (ctrl)
  );

  generate
    for (genvar i = 0; i < W; i++) begin : g_slice
      if (i == 0) begin : g_lsb
        assign less[i] = set_lt;
      end else begin : g_upper
        assign less[i] = 1'b0;
      end
      alu_slice u_slice (
        .a     (a[i]),
        .b     (b[i]),
        .inv_a (ctrl.inv_a),
        .inv_b (ctrl.inv_b),
        .pick  (ctrl.pick),
        .cin   (cy[i]),
        .less  (less[i]),
        .res   (raw[i]),
        .sum   (sum[i]),
        .gen   (gen[i]),
        .prop  (prop[i])
      );
    end
  endgenerate

  alu_carry #(
    .W         (W),
    .GRP       (GRP),
    .LOOKAHEAD (LOOKAHEAD)
  ) u_carry (
    .g   (gen),
    .p   (prop),
    .cin (ctrl.inv_b),
    .c   (cy)
  );

  assign result    = ctrl.legal ? raw : '0;
  assign carry_out = cy[W];

  alu_flags #(.W(W)) u_flags (
    .res        (result),
    .sum_msb    (sum[W-1]),
    .c_into_msb (cy[W-1]),
    .c_out_msb  (cy[W]),
    .zero       (zero),
    .ovf        (overflow),
    .set        (set_lt)
  );

endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk #(
  parameter int W = 32
) (
  input logic [W-1:0] a,
  input logic [W-1:0] b,
  input logic [3:0]   op,
  input logic [W-1:0] result,
  input logic         zero,
  input logic         overflow,
  input logic         carry_out
);

  always_comb begin
    if (op == 4'b0010) begin
      assert_add_sum_R2: assert ({carry_out, result} == ({1'b0, a} + {1'b0, b}))
        else $error("add result/carry mismatch");
      assert_add_ovf_R8: assert (overflow ==
          ((a[W-1] == b[W-1]) && (result[W-1] != a[W-1])))
        else $error("add overflow mismatch");
    end
    if (op == 4'b0110) begin
      assert_sub_diff_R3: assert (result == a - b)
        else $error("sub result mismatch");
      assert_sub_borrow_R9: assert (carry_out == (a >= b))
        else $error("sub carry mismatch");
    end
    if (op == 4'b0111) begin
      assert_slt_signed_R4: assert (result == {{(W-1){1'b0}}, ($signed(a) < $signed(b))})
        else $error("slt mismatch");
    end
    if (!(op inside {4'b0000, 4'b0001, 4'b0010, 4'b0110, 4'b0111, 4'b1100})) begin
      assert_unused_zero_R6: assert (result == '0)
        else $error("unused op gave nonzero result");
    end
    assert_zero_flag_R7: assert (zero == (result == '0))
      else $error("zero flag mismatch");
  end

endmodule

bind alu_core alu_core_chk #(.W(W)) u_alu_core_chk (
  .a         (a),
  .b         (b),
  .op        (op),
  .result    (result),
  .zero      (zero),
  .overflow  (overflow),
  .carry_out (carry_out)
);

// File: tb/tb_alu_core.sv
`timescale 1ns/1ps
module tb_alu_core;

  logic        clk;
  logic [31:0] a;
  logic [31:0] b;
  logic [3:0]  op;
  logic [31:0] result;
  logic        zero;
  logic        overflow;
  logic        carry_out;

  int n_cmp  = 0;
  int n_bad  = 0;
  bit done   = 1'b0;

  alu_core dut (
    .a(a), .b(b), .op(op),
    .result(result), .zero(zero), .overflow(overflow), .carry_out(carry_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // reference built from the requirements
  task automatic expect_of(input logic [31:0] xa, input logic [31:0] xb, input logic [3:0] xo,
                           output logic [31:0] er, output logic ez, output logic ev,
                           output logic ec);
    logic [31:0] aa, bb;
    logic [32:0] s;
    aa = xo[3] ? ~xa : xa;
    bb = xo[2] ? ~xb : xb;
    s  = {1'b0, aa} + {1'b0, bb} + {32'd0, xo[2]};
    ec = s[32];
    ev = (aa[31] == bb[31]) && (s[31] != aa[31]);
    case (xo)
      4'b0000: er = xa & xb;
      4'b0001: er = xa | xb;
      4'b0010: er = xa + xb;
      4'b0110: er = xa - xb;
      4'b0111: er = {31'd0, $signed(xa) < $signed(xb)};
      4'b1100: er = ~(xa | xb);
      default: er = 32'd0;
    endcase
    ez = (er == 32'd0);
  endtask

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input string tag, input logic [31:0] xa, input logic [31:0] xb,
                       input logic [3:0] xo);
    logic [31:0] er;
    logic ez, ev, ec;
    @(negedge clk);
    a = xa; b = xb; op = xo;
    #1;
    expect_of(xa, xb, xo, er, ez, ev, ec);
    cmp(tag, result, er);
    cmp("R7 zero", {31'd0, zero}, {31'd0, ez});
    cmp("R8 overflow", {31'd0, overflow}, {31'd0, ev});
    cmp("R9 carry_out", {31'd0, carry_out}, {31'd0, ec});
  endtask

  task automatic t_idle;
    apply("R1 idle and", 32'h0, 32'h0, 4'b0000);
  endtask

  task automatic t_logic;
    apply("R1 and", 32'hF0F0_1234, 32'hFF00_FF0F, 4'b0000);
    apply("R1 or",  32'hF0F0_1234, 32'h0F00_00C0, 4'b0001);
    apply("R5 nor", 32'hF0F0_1234, 32'h0F00_00C0, 4'b1100);
    apply("R5 nor all zero", 32'h0, 32'h0, 4'b1100);
  endtask

  task automatic t_arith;
    apply("R2 add carry", 32'hFFFF_FFFF, 32'h1, 4'b0010);
    apply("R2 add ovf",   32'h7FFF_FFFF, 32'h1, 4'b0010);
    apply("R2 add neg ovf", 32'h8000_0000, 32'h8000_0000, 4'b0010);
    apply("R2 add group chain", 32'h0FFF_FFFF, 32'h0000_0001, 4'b0010);
    apply("R3 sub equal", 32'h1234_5678, 32'h1234_5678, 4'b0110);
    apply("R3 sub borrow", 32'h0, 32'h1, 4'b0110);
    apply("R3 sub ovf", 32'h8000_0000, 32'h1, 4'b0110);
  endtask

  task automatic t_slt;
    apply("R4 slt min<max", 32'h8000_0000, 32'h7FFF_FFFF, 4'b0111);
    apply("R4 slt max<min", 32'h7FFF_FFFF, 32'h8000_0000, 4'b0111);
    apply("R4 slt neg<pos", 32'hFFFF_FFFF, 32'h0, 4'b0111);
    apply("R4 slt equal", 32'h5, 32'h5, 4'b0111);
    apply("R4 slt small", 32'h3, 32'h9, 4'b0111);
  endtask

  task automatic t_unused;
    for (int k = 0; k < 16; k++) begin
      apply("R6 every code", 32'hA5A5_F00F, 32'h5A5A_0FF1, k[3:0]);
      apply("R6 every code extreme", 32'h8000_0000, 32'h7FFF_FFFF, k[3:0]);
    end
  endtask

  task automatic t_random;
    logic [3:0] codes [6] = '{4'b0000, 4'b0001, 4'b0010, 4'b0110, 4'b0111, 4'b1100};
    for (int n = 0; n < 300; n++) begin
      apply("R2 random", $urandom, $urandom, codes[n % 6]);
    end
  endtask

  initial begin
    a = '0; b = '0; op = '0;
    t_idle();
    t_logic();
    t_arith();
    t_slt();
    t_unused();
    t_random();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule